// File: doc/BRIEF.md
# Event Counter Bank with Overflow Interrupt

This block is a bank of performance counters that sits beside a cache or interconnect. It holds sixteen 64-bit event counters and one 64-bit free-running cycle counter. Each event counter is paired with a select register, and the code stored in that register decides which event strobe the counter follows. A control bit starts and stops every counter together. A counter that rolls over from all ones to zero latches a sticky overflow flag. Any flag whose interrupt enable is set drives a level interrupt until software clears the flag.

Software reaches every register through a plain 64-bit register port: a byte address, a write strobe, write data, and read data that appears one cycle later. This port carries single register accesses and not a data stream, so it has no valid/ready handshake. A write always takes effect, and a read always returns on the following cycle. Event strobes come in as a vector of single-cycle pulses. Software can preload any counter, for example to half of full scale, so that an overflow interrupt arrives after a chosen number of events.

Top module: `evt_count_bank`

## Requirements
- R1: After reset, the control, overflow, enable, select and counter registers all read as zero, and `irq` is low.
- R2: Registers sit at these byte offsets: control 0x040, overflow flags 0x048, interrupt enable 0x050, cycle counter 0x058, select i at 0x060+8*i, event counter i at 0x160+8*i. A read returns data on `reg_rdata` one cycle after the address is presented. Any other address, or any address with a nonzero low three bits, reads as zero.
- R3: Control bit 0 is the run bit. While it is 1, the cycle counter adds one on every clock. While it is 0, no counter changes except through a software write.
- R4: A select code of 0x100+k, for k from 0 to 7, makes its counter add one on each cycle where `evt_strobe[k]` is high. Any other code makes the counter count nothing. Only the low 32 bits of a select write are stored, and the upper bits read as zero.
- R5: A counter that steps from all ones to zero sets its overflow flag on that same clock edge. Event counter i uses flag bit i, and the cycle counter uses bit 63.
- R6: Writing the overflow register clears each flag whose data bit is 1 and leaves each flag whose data bit is 0 unchanged.
- R7: `irq` is high exactly when some overflow flag and its enable bit are both set, and it stays high until that condition ends.
- R8: Only enable bits 0 to 15 and bit 63 are stored. All other enable and flag bits read as zero.
- R9: When a software write to a counter and an increment of that counter happen in the same cycle, the written value is kept and no overflow is flagged.
- R10: When a rollover sets a flag in the same cycle that a write-one clear targets it, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, one cycle after the address |
| evt_strobe | input | 8 | Single-cycle event pulses |
| irq | output | 1 | Level interrupt: some enabled overflow flag is set |

## Verification
The assertions check on every cycle the properties that hold locally at each edge:
- a loaded counter holds the written value;
- a rollover lands on zero, and its flag is set and survives a clear in the same cycle;
- flags never drop without a write-one clear;
- an idle cycle counter stays still;
- unmapped reads return zero;
- an enabled rollover raises the interrupt.

Only the bench scenarios can show the properties that depend on sequences of operations. These are the exact counts taken over an enabled window, a select code that maps to no strobe, the stored width of the select and enable registers, and interrupt masking followed by unmasking.

// File: rtl/ecb_pkg.sv
`timescale 1ns/1ps
package ecb_pkg;
  // Byte offsets of the register map; software depends on these.
  localparam int OFS_CTRL = 'h040;
  localparam int OFS_STAT = 'h048;
  localparam int OFS_IEN  = 'h050;
  localparam int OFS_CYC  = 'h058;
  localparam int OFS_SEL  = 'h060;
  localparam int OFS_CNT  = 'h160;

  // First select code that maps to a strobe; code BASE+k picks strobe k.
  localparam int EVT_CODE_BASE = 'h100;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_CTRL,
    RK_STAT,
    RK_IEN,
    RK_CYC,
    RK_SEL,
    RK_CNT
  } reg_kind_e;
endpackage

// File: rtl/ecb_event_map.sv
`timescale 1ns/1ps
module ecb_event_map #(
  parameter int NUM_EVT = 8,
  parameter int SEL_W   = 32
) (
  input  logic [SEL_W-1:0]   code,
  input  logic [NUM_EVT-1:0] strobe,
  output logic               hit
);
  import ecb_pkg::*;

  logic [NUM_EVT-1:0] match;

  // One comparator per supported code; codes outside the table never match.
  for (genvar k = 0; k < NUM_EVT; k++) begin : g_code
    localparam logic [SEL_W-1:0] CODE_K = SEL_W'(EVT_CODE_BASE + k);
    assign match[k] = (code == CODE_K);
  end

  assign hit = |(match & strobe);
endmodule

// File: rtl/ecb_counter.sv
`timescale 1ns/1ps
module ecb_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (ld)  cnt <= ld_val;
    else if (inc) cnt <= cnt + 1'b1;
  end

  // A rollover happens only on a real increment from all ones; a load suppresses it.
  assign wrap = inc && !ld && (&cnt);

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cnt == $past(ld_val)); // R9

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == '0); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !inc) |=> $stable(cnt)); // R3
endmodule

// File: rtl/evt_count_bank.sv
`timescale 1ns/1ps
module evt_count_bank #(
  parameter int NUM_CTR = 16,
  parameter int DW      = 64,
  parameter int AW      = 12,
  parameter int NUM_EVT = 8,
  parameter int SEL_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      reg_addr,
  input  logic               reg_wr,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  input  logic [NUM_EVT-1:0] evt_strobe,
  output logic               irq
);
  import ecb_pkg::*;

  localparam int IW      = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;
  localparam int WW      = AW - 3;
  localparam int CYC_BIT = DW - 1;
  localparam int WI_CTRL = OFS_CTRL / 8;
  localparam int WI_STAT = OFS_STAT / 8;
  localparam int WI_IEN  = OFS_IEN / 8;
  localparam int WI_CYC  = OFS_CYC / 8;
  localparam int WI_SEL  = OFS_SEL / 8;
  localparam int WI_CNT  = OFS_CNT / 8;
  localparam logic [DW-1:0] VEC_MASK =
    {1'b1, {(DW-1-NUM_CTR){1'b0}}, {NUM_CTR{1'b1}}};

  // ---------------- address decode ----------------
  reg_kind_e     kind;
  logic [IW-1:0] idx;
  logic [WW-1:0] wi;

  assign wi = reg_addr[AW-1:3];

  always_comb begin
    kind = RK_NONE;
    idx  = '0;
    if (reg_addr[2:0] == 3'b000) begin
      if (int'(wi) == WI_CTRL)      kind = RK_CTRL;
      else if (int'(wi) == WI_STAT) kind = RK_STAT;
      else if (int'(wi) == WI_IEN)  kind = RK_IEN;
      else if (int'(wi) == WI_CYC)  kind = RK_CYC;
      else if (int'(wi) >= WI_SEL && int'(wi) < WI_SEL + NUM_CTR) begin
        kind = RK_SEL;
        idx  = IW'(int'(wi) - WI_SEL);
      end else if (int'(wi) >= WI_CNT && int'(wi) < WI_CNT + NUM_CTR) begin
        kind = RK_CNT;
        idx  = IW'(int'(wi) - WI_CNT);
      end
    end
  end

  logic ctrl_we, stat_we, ien_we, cyc_we;
  assign ctrl_we = reg_wr && (kind == RK_CTRL);
  assign stat_we = reg_wr && (kind == RK_STAT);
  assign ien_we  = reg_wr && (kind == RK_IEN);
  assign cyc_we  = reg_wr && (kind == RK_CYC);

  // ---------------- control and enable ----------------
  logic          run_q;
  logic [DW-1:0] ien_q;
  logic [DW-1:0] ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ien_q <= '0;
    end else begin
      if (ctrl_we) run_q <= reg_wdata[0];
      if (ien_we)  ien_q <= reg_wdata & VEC_MASK;
    end
  end

  // ---------------- event counters ----------------
  logic [SEL_W-1:0] sel_q   [NUM_CTR];
  logic [DW-1:0]    evt_cnt [NUM_CTR];
  logic [NUM_CTR-1:0] evt_wrap;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    logic sel_we, cnt_we, hit;

    assign sel_we = reg_wr && (kind == RK_SEL) && (idx == IW'(i));
    assign cnt_we = reg_wr && (kind == RK_CNT) && (idx == IW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n)      sel_q[i] <= '0;
      else if (sel_we) sel_q[i] <= reg_wdata[SEL_W-1:0];
    end

    ecb_event_map #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_map (
      .code   (sel_q[i]),
      .strobe (evt_strobe),
      .hit    (hit)
    );

    ecb_counter #(.W(DW)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc    (run_q && hit),
      .ld     (cnt_we),
      .ld_val (reg_wdata),
      .cnt    (evt_cnt[i]),
      .wrap   (evt_wrap[i])
    );
  end

  // ---------------- cycle counter ----------------
  logic [DW-1:0] cyc_cnt;
  logic          cyc_wrap;

  ecb_counter #(.W(DW)) u_cyc (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (run_q),
    .ld     (cyc_we),
    .ld_val (reg_wdata),
    .cnt    (cyc_cnt),
    .wrap   (cyc_wrap)
  );

  // ---------------- overflow flags ----------------
  logic [DW-1:0] wrap_v;
  logic [DW-1:0] clr_v;

  always_comb begin
    wrap_v = '0;
    for (int i = 0; i < NUM_CTR; i++) wrap_v[i] = evt_wrap[i];
    wrap_v[CYC_BIT] = cyc_wrap;
  end

  assign clr_v = stat_we ? reg_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) ovf_q <= '0;
    else        ovf_q <= ((ovf_q & ~clr_v) | wrap_v) & VEC_MASK;
  end

  assign irq = |(ovf_q & ien_q);

  // ---------------- read path ----------------
  logic [DW-1:0] rd_next;

  always_comb begin
    unique case (kind)
      RK_CTRL: rd_next = DW'(run_q);
      RK_STAT: rd_next = ovf_q;
      RK_IEN:  rd_next = ien_q;
      RK_CYC:  rd_next = cyc_cnt;
      RK_SEL:  rd_next = DW'(sel_q[idx]);
      RK_CNT:  rd_next = evt_cnt[idx];
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= rd_next;
  end

  // ---------------- assertions ----------------
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == RK_NONE) |=> reg_rdata == '0); // R2

  AST_CYC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cyc_we) |=> $stable(cyc_cnt)); // R3

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_we |=> (ovf_q & $past(ovf_q)) == $past(ovf_q)); // R6

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && wrap_v == '0) |=> (ovf_q & $past(reg_wdata)) == '0); // R6

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_v != '0) |=> (ovf_q & $past(wrap_v)) == $past(wrap_v)); // R10

  AST_IRQ_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((wrap_v & ien_q) != '0 && !ien_we) |=> irq); // R7
endmodule

// File: tb/sim_evt_count_bank.sv
`timescale 1ns/1ps
module sim_evt_count_bank;
  localparam logic [63:0] ONES = '1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic [7:0]  evt_strobe = '0;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  logic rd_pend = 1'b0;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk; // 50 MHz

  evt_count_bank u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_strobe(evt_strobe), .irq(irq)
  );

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // One cycle of stimulus, started and ended at a falling edge.
  task automatic drive(input logic [11:0] a, input logic w, input logic [63:0] d,
                       input logic [7:0] s);
    reg_addr = a; reg_wr = w; reg_wdata = d; evt_strobe = s;
    @(negedge clk);
    reg_wr = 1'b0; evt_strobe = '0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    drive(a, 1'b1, d, 8'h00);
  endtask

  task automatic pulse(input logic [7:0] s);
    drive(12'h000, 1'b0, '0, s);
  endtask

  // Driver: the expected read value goes to the scoreboard.
  task automatic rd(input logic [11:0] a, input logic [63:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    reg_addr = a; reg_wr = 1'b0; rd_pend = 1'b1;
    @(negedge clk);
    rd_pend = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_cmp++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s irq: got %0b expected %0b", t, irq, e);
    end
  endtask

  // Monitor: pops one expected item per read once the data is out.
  always @(posedge clk) begin
    if (rd_pend) begin
      #5;
      if (exp_q.size() > 0) begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (reg_rdata !== e) begin
          n_bad++;
          $display("FAIL %s: got %h expected %h", t, reg_rdata, e);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(12'h040, 64'h0, "R1 control");
    rd(12'h048, 64'h0, "R1 flags");
    rd(12'h050, 64'h0, "R1 enable");
    rd(12'h058, 64'h0, "R1 cycle");
    rd(12'h160, 64'h0, "R1 counter0");
    rd(12'h060, 64'h0, "R1 select0");
    chk_irq(1'b0, "R1");

    // R4 select codes: ctr0 <- strobe0, ctr1 <- strobe3, ctr2 unmapped
    wr(12'h060, 64'h100);
    wr(12'h068, 64'h103);
    wr(12'h070, 64'h1234);
    wr(12'h040, 64'h1);
    repeat (3) pulse(8'h01);
    repeat (2) pulse(8'h09);
    pulse(8'hFF);
    wr(12'h040, 64'h0);
    rd(12'h160, 64'd6, "R4 counter0 strobe0");
    rd(12'h168, 64'd3, "R4 counter1 strobe3");
    rd(12'h170, 64'd0, "R4 counter2 unmapped code");

    // R3 halted: strobes have no effect
    repeat (2) pulse(8'hFF);
    rd(12'h160, 64'd6, "R3 halted counter0");
    rd(12'h168, 64'd3, "R3 halted counter1");

    // R3 cycle counter over an 11-edge window
    wr(12'h058, 64'h0);
    wr(12'h040, 64'h1);
    repeat (10) @(negedge clk);
    wr(12'h040, 64'h0);
    rd(12'h058, 64'd11, "R3 cycle count");
    rd(12'h040, 64'h0, "R2 control readback");

    // R5 event rollover with interrupt enabled
    wr(12'h160, ONES - 64'd1);
    wr(12'h050, 64'h1);
    wr(12'h040, 64'h1);
    repeat (2) pulse(8'h01);
    wr(12'h040, 64'h0);
    rd(12'h160, 64'h0, "R5 counter0 wrapped");
    rd(12'h048, 64'h1, "R5 flag0 set");
    chk_irq(1'b1, "R7 enabled flag");

    // R6 write-one-to-clear
    wr(12'h048, 64'h0);
    rd(12'h048, 64'h1, "R6 zero write keeps flag");
    chk_irq(1'b1, "R6 flag kept");
    wr(12'h048, 64'h1);
    rd(12'h048, 64'h0, "R6 one write clears flag");
    chk_irq(1'b0, "R7 cleared");

    // R7 masked flag, then unmasked
    wr(12'h168, ONES);
    wr(12'h040, 64'h1);
    pulse(8'h08);
    wr(12'h040, 64'h0);
    rd(12'h048, 64'h2, "R5 flag1 set");
    chk_irq(1'b0, "R7 masked flag");
    wr(12'h050, 64'h3);
    chk_irq(1'b1, "R7 unmasked flag");
    wr(12'h048, 64'h2);
    chk_irq(1'b0, "R7 after clear");

    // R5 cycle counter rollover on bit 63
    wr(12'h058, ONES - 64'd2);
    wr(12'h050, 64'h8000_0000_0000_0003);
    wr(12'h040, 64'h1);
    repeat (4) @(negedge clk);
    wr(12'h040, 64'h0);
    rd(12'h058, 64'h2, "R5 cycle wrapped");
    rd(12'h048, 64'h8000_0000_0000_0000, "R5 flag63 set");
    chk_irq(1'b1, "R7 cycle flag");
    wr(12'h048, 64'h8000_0000_0000_0000);
    chk_irq(1'b0, "R6 flag63 cleared");

    // R9 software write beats increment; no flag on a loaded all-ones value
    wr(12'h040, 64'h1);
    drive(12'h160, 1'b1, 64'd100, 8'h01);
    rd(12'h160, 64'd100, "R9 write wins");
    drive(12'h160, 1'b1, ONES, 8'h01);
    wr(12'h040, 64'h0);
    rd(12'h160, ONES, "R9 loaded all ones");
    rd(12'h048, 64'h0, "R9 no flag on load");

    // R10 set beats a clear in the same cycle
    wr(12'h040, 64'h1);
    drive(12'h048, 1'b1, 64'h1, 8'h01);
    wr(12'h040, 64'h0);
    rd(12'h048, 64'h1, "R10 set wins");
    rd(12'h160, 64'h0, "R10 counter0 wrapped");

    // R2 unmapped and misaligned addresses
    rd(12'h008, 64'h0, "R2 unmapped low");
    rd(12'h1E0, 64'h0, "R2 unmapped past counters");
    rd(12'h164, 64'h0, "R2 misaligned");

    // R4 select width, R8 enable width
    wr(12'h068, 64'hFFFF_FFFF_0000_0103);
    rd(12'h068, 64'h103, "R4 select low 32 bits");
    wr(12'h050, ONES);
    rd(12'h050, 64'h8000_0000_0000_FFFF, "R8 enable mask");
    wr(12'h048, ONES);
    rd(12'h048, 64'h0, "R8 flags cleared");

    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule